// File: doc/BRIEF.md
# Clamped Three-Level Leg Commutation Sequencer

This block drives the six gates of one phase leg of a three-level converter whose neutral paths are switched by active devices. The leg rests in one of seven output states: the positive rail, the negative rail, or one of five zero states that tie the output to the neutral point through the upper path, the lower path, or both. A controller asks for a new state with a code and a one-cycle strobe. The block then walks the gates from the present pattern to the requested one. It changes one gate at a time, in an order fixed for each pair of states, and waits a programmable dead-time between steps.

Requests are accepted only while the leg is idle. A pair of states with no defined commutation is refused, and the refusal is shown as a one-cycle error pulse. After reset every gate is off, and the leg can only be brought up into one of the two rail states.

Top module: `clamp_leg_sequencer`

## Requirements
- R1: After reset, `gate_on` is 0, `busy` is 0, `req_err` is 0 and `leg_state` is 7 (dark). `gate_on` stays 0 for as long as `leg_state` is 7.
- R2: The state codes are 0 positive, 1 upper-zero hold, 2 upper-zero, 3 both-paths, 4 lower-zero hold, 5 lower-zero, 6 negative, 7 dark. `gate_on` bits 0..5 are: upper outer, upper inner, lower inner, lower outer, upper clamp, lower clamp. While idle in a non-dark state, `gate_on` equals that state's pattern: 0=100011, 1=011010, 2=010010, 3=110110, 4=100101, 5=100100, 6=011100 (bit 5 first).
- R3: From dark, only code 0 or 6 is accepted. The gates stay off at the acceptance edge, and every on-bit of the target pattern is set together one dead-time later.
- R4: From positive, bits are toggled in this order: to 2, bits 5,0,4; to 1, bits 5,0,4,3; to 5, bits 0,2,1; to 4, bits 2,1.
- R5: From negative, bits are toggled in this order: to 5, bits 4,3,5; to 4, bits 4,3,5,0; to 2, bits 3,1,2; to 1, bits 1,2.
- R6: Entering both-paths uses bits 2,5 from code 2 and bits 1,4 from code 5.
- R7: Every transition in R4 to R6 may also be requested in reverse. The reverse uses the same bits in the opposite order.
- R8: The first toggle happens at the acceptance edge. Each later toggle happens D clock cycles after the previous one, where D is `dead_cyc` sampled at acceptance, and a value of 0 counts as 1.
- R9: `busy` is high from the acceptance edge until the edge of the last toggle. `leg_state` keeps the old code while `busy` is high and takes the target code at that last edge.
- R10: A request made while `busy` is high is ignored. It does not raise `req_err` and does not change the sequence in progress.
- R11: An idle request for a pair not covered by R3 to R7 is refused: either the same state, the dark code, or an undefined pair. A refusal raises `req_err` for exactly one cycle and leaves the gates and the state unchanged.
- R12: Except when leaving dark, at most one gate changes on any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tgt_code | input | 3 | Requested state code |
| tgt_req | input | 1 | Request strobe |
| dead_cyc | input | DW | Dead-time in clock cycles (0 means 1) |
| gate_on | output | 6 | Gate enables, bit order per R2 |
| busy | output | 1 | Commutation in progress |
| leg_state | output | 3 | Current settled state code |
| req_err | output | 1 | One-cycle pulse on a refused request |

## Verification
The bench walks a script that takes every defined transition in both directions. Before each move it tries every code the current state must refuse. A design with a wrong order, or one that reversed a sequence without inverting the order, would show an intermediate gate pattern that differs in the cycle-by-cycle comparison. A design that counted the dead-time off by one, or that let a zero dead-time produce back-to-back gaps of zero, would toggle a cycle early or late and fail the per-cycle timing check. A request injected while the leg is busy catches a design that restarts its sequence or flags an error. The refusal sweep catches a design that accepts the same-state code, the dark code, or a rail-to-both-paths jump.

// File: rtl/clamp_leg_sequencer.sv
module clamp_leg_sequencer #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    tgt_code,
  input  logic          tgt_req,
  input  logic [DW-1:0] dead_cyc,
  output logic [5:0]    gate_on,
  output logic          busy,
  output logic [2:0]    leg_state,
  output logic          req_err
);

  localparam int NSTEP = 4;
  localparam int IW    = $clog2(NSTEP);
  localparam logic [2:0] ST_POS = 3'd0, ST_UPH = 3'd1, ST_UP = 3'd2, ST_BOTH = 3'd3,
                         ST_LOH = 3'd4, ST_LO  = 3'd5, ST_NEG = 3'd6, ST_OFF = 3'd7;

  function automatic logic [5:0] pattern(input logic [2:0] s);
    case (s)
      ST_POS:  pattern = 6'b100011;
      ST_UPH:  pattern = 6'b011010;
      ST_UP:   pattern = 6'b010010;
      ST_BOTH: pattern = 6'b110110;
      ST_LOH:  pattern = 6'b100101;
      ST_LO:   pattern = 6'b100100;
      ST_NEG:  pattern = 6'b011100;
      default: pattern = 6'b000000;
    endcase
  endfunction

  // switch numbers 1..6 (bit+1), first step in the low field, 0 = unused
  function automatic logic [3*NSTEP-1:0] order(input logic [2:0] f, input logic [2:0] t);
    case ({f, t})
      {ST_POS, ST_UP}:   order = {3'd0, 3'd5, 3'd1, 3'd6};
      {ST_POS, ST_UPH}:  order = {3'd4, 3'd5, 3'd1, 3'd6};
      {ST_POS, ST_LO}:   order = {3'd0, 3'd2, 3'd3, 3'd1};
      {ST_POS, ST_LOH}:  order = {3'd0, 3'd0, 3'd2, 3'd3};
      {ST_NEG, ST_LO}:   order = {3'd0, 3'd6, 3'd4, 3'd5};
      {ST_NEG, ST_LOH}:  order = {3'd1, 3'd6, 3'd4, 3'd5};
      {ST_NEG, ST_UP}:   order = {3'd0, 3'd3, 3'd2, 3'd4};
      {ST_NEG, ST_UPH}:  order = {3'd0, 3'd0, 3'd3, 3'd2};
      {ST_UP,  ST_BOTH}: order = {3'd0, 3'd0, 3'd6, 3'd3};
      {ST_LO,  ST_BOTH}: order = {3'd0, 3'd0, 3'd5, 3'd2};
      default:           order = '0;
    endcase
  endfunction

  function automatic logic [5:0] onehot(input logic [2:0] sw);
    onehot = (sw == 3'd0) ? 6'd0 : (6'd1 << (sw - 3'd1));
  endfunction

  function automatic logic [2:0] used(input logic [3*NSTEP-1:0] o);
    used = '0;
    for (int i = 0; i < NSTEP; i++)
      if (o[3*i +: 3] != 3'd0) used = used + 3'd1;
  endfunction

  logic [3*NSTEP-1:0]     ord_f, ord_r;
  logic [NSTEP-1:0][5:0]  seq_c, seq_q;
  logic [2:0]             nsteps, idx_q, last_q, tgt_q;
  logic                   legal;
  logic [DW-1:0]          eff, dt_q, cnt_q;

  assign ord_f = order(leg_state, tgt_code);
  assign ord_r = order(tgt_code, leg_state);
  assign eff   = (dead_cyc == '0) ? DW'(1) : dead_cyc;

  always_comb begin
    legal  = 1'b0;
    nsteps = 3'd0;
    seq_c  = '0;
    if (leg_state == ST_OFF) begin
      if (tgt_code == ST_POS || tgt_code == ST_NEG) begin
        legal    = 1'b1;
        nsteps   = 3'd2;
        seq_c[1] = pattern(tgt_code);
      end
    end else if (ord_f != '0) begin
      legal  = 1'b1;
      nsteps = used(ord_f);
      for (int i = 0; i < NSTEP; i++) seq_c[i] = onehot(ord_f[3*i +: 3]);
    end else if (ord_r != '0) begin
      legal  = 1'b1;
      nsteps = used(ord_r);
      for (int i = 0; i < NSTEP; i++)
        if (i < int'(nsteps)) seq_c[i] = onehot(ord_r[3*(int'(nsteps)-1-i) +: 3]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_on   <= '0;
      busy      <= 1'b0;
      leg_state <= ST_OFF;
      req_err   <= 1'b0;
      seq_q     <= '0;
      idx_q     <= '0;
      last_q    <= '0;
      tgt_q     <= ST_OFF;
      dt_q      <= DW'(1);
      cnt_q     <= DW'(1);
    end else begin
      req_err <= 1'b0;
      if (!busy) begin
        if (tgt_req) begin
          if (legal) begin
            gate_on <= gate_on ^ seq_c[0];
            seq_q   <= seq_c;
            last_q  <= nsteps - 3'd1;
            idx_q   <= 3'd1;
            dt_q    <= eff;
            cnt_q   <= eff;
            tgt_q   <= tgt_code;
            busy    <= 1'b1;
          end else begin
            req_err <= 1'b1;
          end
        end
      end else if (cnt_q > DW'(1)) begin
        cnt_q <= cnt_q - DW'(1);
      end else begin
        gate_on <= gate_on ^ seq_q[idx_q[IW-1:0]];
        if (idx_q == last_q) begin
          busy      <= 1'b0;
          leg_state <= tgt_q;
        end else begin
          idx_q <= idx_q + 3'd1;
          cnt_q <= dt_q;
        end
      end
    end
  end

  AST_OFF_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    leg_state == ST_OFF |-> gate_on == 6'd0); // R1
  AST_IDLE_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && leg_state != ST_OFF) |-> gate_on == pattern(leg_state)); // R2
  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(leg_state)); // R9
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !$past(busy)); // R10
  AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(leg_state) != ST_OFF |-> $countones(gate_on ^ $past(gate_on)) <= 1); // R12

endmodule

// File: tb/clamp_leg_sequencer_bench.sv
`timescale 1ns/1ps
module clamp_leg_sequencer_bench;
  localparam int DW = 8;
  logic clk = 1'b0, rst_n = 1'b0, tgt_req = 1'b0;
  logic [2:0] tgt_code = 3'd0;
  logic [DW-1:0] dead_cyc = '0;
  logic [5:0] gate_on;
  logic busy, req_err;
  logic [2:0] leg_state;
  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [2:0] cur = 3'd7;
  logic [5:0] cur_g = 6'd0;

  always #2 clk = ~clk;

  clamp_leg_sequencer #(.DW(DW)) u_clamp_leg_sequencer (
    .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .tgt_req(tgt_req), .dead_cyc(dead_cyc),
    .gate_on(gate_on), .busy(busy), .leg_state(leg_state), .req_err(req_err));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] b_pat(input logic [2:0] s);
    case (s)
      3'd0: return 6'b100011;  3'd1: return 6'b011010;
      3'd2: return 6'b010010;  3'd3: return 6'b110110;
      3'd4: return 6'b100101;  3'd5: return 6'b100100;
      3'd6: return 6'b011100;  default: return 6'b000000;
    endcase
  endfunction

  // bit indices in toggle order, -1 terminated
  function automatic int b_fwd(input logic [2:0] f, input logic [2:0] t, input int k);
    int s[4];
    s = '{-1, -1, -1, -1};
    case ({f, t})
      {3'd0, 3'd2}: s = '{5, 0, 4, -1};
      {3'd0, 3'd1}: s = '{5, 0, 4, 3};
      {3'd0, 3'd5}: s = '{0, 2, 1, -1};
      {3'd0, 3'd4}: s = '{2, 1, -1, -1};
      {3'd6, 3'd5}: s = '{4, 3, 5, -1};
      {3'd6, 3'd4}: s = '{4, 3, 5, 0};
      {3'd6, 3'd2}: s = '{3, 1, 2, -1};
      {3'd6, 3'd1}: s = '{1, 2, -1, -1};
      {3'd2, 3'd3}: s = '{2, 5, -1, -1};
      {3'd5, 3'd3}: s = '{1, 4, -1, -1};
      default: ;
    endcase
    return s[k];
  endfunction

  function automatic int b_len(input logic [2:0] f, input logic [2:0] t);
    int n = 0;
    for (int k = 0; k < 4; k++) if (b_fwd(f, t, k) >= 0) n++;
    return n;
  endfunction

  // returns step count (0 = refused), fills masks
  function automatic int b_build(input logic [2:0] f, input logic [2:0] t, output logic [5:0] m[4]);
    int n;
    for (int k = 0; k < 4; k++) m[k] = 6'd0;
    if (f == 3'd7) begin
      if (t != 3'd0 && t != 3'd6) return 0;
      m[1] = b_pat(t);
      return 2;
    end
    n = b_len(f, t);
    if (n > 0) begin
      for (int k = 0; k < n; k++) m[k] = 6'd1 << b_fwd(f, t, k);
      return n;
    end
    n = b_len(t, f);
    for (int k = 0; k < n; k++) m[k] = 6'd1 << b_fwd(t, f, n - 1 - k);
    return n;
  endfunction

  function automatic string mtag(input logic [2:0] f, input logic [2:0] t);
    if (f == 3'd7) return "R3";
    if (f == 3'd3 || t == 3'd3) return "R6";
    if (b_len(f, t) == 0) return "R7";
    return (f == 3'd0) ? "R4" : "R5";
  endfunction

  task automatic do_reject(input logic [2:0] t);
    @(negedge clk);
    tgt_code = t; tgt_req = 1'b1; dead_cyc = 8'd2;
    @(negedge clk);
    tgt_req = 1'b0;
    chk(req_err == 1'b1, "R11 err pulse", int'(req_err), 1);
    chk(gate_on == cur_g && leg_state == cur && !busy, "R11 unchanged",
        int'({busy, leg_state, gate_on}), int'({1'b0, cur, cur_g}));
    @(negedge clk);
    chk(req_err == 1'b0, "R11 single cycle", int'(req_err), 0);
  endtask

  task automatic do_move(input logic [2:0] t, input int d, input bit intrude);
    logic [5:0] m[4];
    logic [5:0] expg, prev;
    int n, de, k, total;
    bit eb;
    string tg;
    n = b_build(cur, t, m);
    de = (d == 0) ? 1 : d;
    total = (n - 1) * de;
    tg = mtag(cur, t);
    prev = cur_g;
    expg = cur_g;
    @(negedge clk);
    tgt_code = t; tgt_req = 1'b1; dead_cyc = DW'(d);
    for (int c = 0; c <= total; c++) begin
      @(negedge clk);
      tgt_req = intrude && c == 0;
      if (intrude && c == 0) begin tgt_code = 3'd5; dead_cyc = 8'd7; end
      k = 1 + c / de;
      if (k > n) k = n;
      expg = cur_g;
      for (int j = 0; j < k; j++) expg = expg ^ m[j];
      chk(gate_on == expg, {tg, " R8 gate step"}, int'(gate_on), int'(expg));
      eb = c < total;
      chk(busy == eb, "R9 busy", int'(busy), int'(eb));
      chk(leg_state == (eb ? cur : t), "R9 state", int'(leg_state), int'(eb ? cur : t));
      chk(req_err == 1'b0, intrude ? "R10 no err" : "R11 no err", int'(req_err), 0);
      if (cur != 3'd7)
        chk($countones(gate_on ^ prev) <= 1, "R12 single flip", int'(gate_on ^ prev), 0);
      prev = gate_on;
    end
    chk(gate_on == b_pat(t), "R2 final pattern", int'(gate_on), int'(b_pat(t)));
    cur = t;
    cur_g = expg;
  endtask

  initial begin
    logic [2:0] script[22];
    logic [5:0] mm[4];
    script = '{3'd1, 3'd0, 3'd2, 3'd0, 3'd4, 3'd0, 3'd5, 3'd0, 3'd2, 3'd3, 3'd2,
               3'd6, 3'd1, 3'd6, 3'd4, 3'd6, 3'd5, 3'd3, 3'd5, 3'd6, 3'd2, 3'd0};
    repeat (3) @(negedge clk);
    chk(gate_on == 6'd0 && !busy && !req_err && leg_state == 3'd7, "R1 reset",
        int'({req_err, busy, leg_state, gate_on}), int'({1'b0, 1'b0, 3'd7, 6'd0}));
    rst_n = 1'b1;
    for (int t = 0; t < 8; t++)
      if (b_build(cur, 3'(t), mm) == 0) do_reject(3'(t));
    do_move(3'd0, 3, 1'b0);
    for (int i = 0; i < 22; i++) begin
      for (int t = 0; t < 8; t++)
        if (b_build(cur, 3'(t), mm) == 0) do_reject(3'(t));
      do_move(script[i], i % 4, i == 3 || i == 12);
    end
    repeat (2) @(negedge clk);
    chk(gate_on == b_pat(3'd0) && leg_state == 3'd0, "R2 idle hold",
        int'(gate_on), int'(b_pat(3'd0)));
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule